// File: doc/BRIEF.md
# ASCII Multiply/Divide Adjust Unit

This unit performs the two base-parameterised ASCII adjust operations on a 16-bit accumulator made of a high byte (AH) and a low byte (AL). In divide mode it splits AL by an 8-bit base: the quotient goes to the high byte and the remainder to the low byte. In multiply mode it folds the two bytes back into one value, AH times the base plus AL, and keeps only the low byte with the high byte cleared. Both modes produce a logic-style flag set from the resulting low byte. A divide by a zero base is reported as a fault, and the accumulator is left untouched.

The caller pulses `start_i` with the mode, accumulator and base, then waits for `done_o`. Division runs on a restoring shift-subtract engine, one quotient bit per cycle. Multiplication runs on a shift-add engine, one multiplier bit per cycle. A zero base in divide mode is caught in the accepting cycle, so no iterations run. Results stay on the outputs until a later operation completes.

Top module: `ascii_adjust_md`

## Requirements
- R1: In divide mode (`mode_i`=0) with a nonzero base, `acc_o[15:8]` becomes the unsigned quotient of `acc_i[7:0]` by `base_i`, and `acc_o[7:0]` becomes the remainder. `acc_i[15:8]` has no effect on the result.
- R2: In divide mode with `base_i`=0, `div_err_o` and `done_o` are both high in the cycle that follows the accepting edge. `acc_o` and `flags_o` keep their previous values, and `div_err_o` is never high without `done_o`.
- R3: In multiply mode (`mode_i`=1), `acc_o[7:0]` becomes the low byte of the 16-bit sum `acc_i[15:8]*base_i + acc_i[7:0]`, and `acc_o[15:8]` becomes 0. A zero base is legal in this mode.
- R4: On a completed operation, `flags_o` is set from the result byte r=`acc_o[7:0]` with this bit mapping: bit0 carry=0, bit1 parity=1 when r has an even number of ones, bit2 auxiliary=0, bit3 zero=(r==0), bit4 sign=r[7], bit5 overflow=0.
- R5: A non-faulting operation raises `done_o` in the cycle after the ninth rising edge that follows the edge accepting `start_i`.
- R6: `done_o` is high for exactly one cycle per accepted operation.
- R7: `start_i` is ignored while an operation is in progress. Operands presented then do not alter the running result and do not produce an extra `done_o`.
- R8: `acc_o` and `flags_o` hold their values in every cycle without `done_o`, whatever the inputs do.
- R9: Reset, including a reset in the middle of an operation, clears `acc_o`, `flags_o`, `done_o` and `div_err_o` and abandons the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a new operation (taken only when idle) |
| mode_i | input | 1 | 0 = divide adjust, 1 = multiply adjust |
| acc_i | input | 16 | Accumulator operand, high byte AH and low byte AL |
| base_i | input | 8 | Immediate base |
| acc_o | output | 16 | Result accumulator |
| flags_o | output | 6 | Result flags {OF,SF,ZF,AF,PF,CF} |
| div_err_o | output | 1 | Divide-by-zero fault strobe |
| done_o | output | 1 | Completion strobe |

## Verification
A bad divider step or a wrong restore decision changes the quotient or remainder. Such an error first appears at `acc_o` in the completion cycle, nine edges after acceptance, and the sweep over every AL value with several bases exposes it. A bad multiplier shift or a lost carry shows up the same way, in the low byte or as a nonzero high byte. A stuck or early busy state shows as a missing, late, early or extra `done_o` pulse, which the fixed latency check and the start-while-busy test catch within one operation. A fault path that writes state shows at once, in the fault cycle, as a changed `acc_o` or `flags_o`.

// File: rtl/adj_pkg.sv
package adj_pkg;
  localparam logic MODE_DIV = 1'b0;
  localparam logic MODE_MUL = 1'b1;

  localparam int FLAG_W = 6;
  localparam int FLG_CF = 0;
  localparam int FLG_PF = 1;
  localparam int FLG_AF = 2;
  localparam int FLG_ZF = 3;
  localparam int FLG_SF = 4;
  localparam int FLG_OF = 5;
endpackage

// File: rtl/adj_divider.sv
module adj_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         fin_o
);
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic             active_q, active_d;
  logic             fin_q, fin_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     rem_q, rem_d;
  logic [W-1:0]     quo_q, quo_d;
  logic [W-1:0]     dvs_q, dvs_d;
  logic [W:0]       trial, diff;
  logic             fits;
  logic             en;

  // one restoring step: shift in next dividend bit, trial-subtract
  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, dvs_q};
    fits  = (trial >= {1'b0, dvs_q});
  end

  always_comb begin
    active_d = active_q;
    fin_d    = 1'b0;
    cnt_d    = cnt_q;
    rem_d    = rem_q;
    quo_d    = quo_q;
    dvs_d    = dvs_q;
    if (load_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
      rem_d    = '0;
      quo_d    = dividend_i;
      dvs_d    = divisor_i;
    end else if (active_q) begin
      quo_d = {quo_q[W-2:0], fits};
      rem_d = fits ? diff[W-1:0] : trial[W-1:0];
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        active_d = 1'b0;
        fin_d    = 1'b1;
      end
    end
  end

  assign en = load_i | active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fin_q    <= 1'b0;
      cnt_q    <= '0;
      rem_q    <= '0;
      quo_q    <= '0;
      dvs_q    <= '0;
    end else begin
      active_q <= active_d;
      fin_q    <= fin_d;
      if (en) begin
        cnt_q <= cnt_d;
        rem_q <= rem_d;
        quo_q <= quo_d;
        dvs_q <= dvs_d;
      end
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
  assign fin_o = fin_q;

  // R1
  rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (rem_q < dvs_q));

  // R2
  no_zero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (dvs_q != '0));
endmodule

// File: rtl/adj_multiplier.sv
module adj_multiplier #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  input  logic [W-1:0] addend_i,
  output logic [W-1:0] prod_lo_o,
  output logic         fin_o
);
  localparam int PW    = 2 * W;
  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic             active_q, active_d;
  logic             fin_q, fin_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PW-1:0]    sum_q, sum_d;
  logic [PW-1:0]    mc_q, mc_d;
  logic [W-1:0]     mp_q, mp_d;
  logic             en;

  always_comb begin
    active_d = active_q;
    fin_d    = 1'b0;
    cnt_d    = cnt_q;
    sum_d    = sum_q;
    mc_d     = mc_q;
    mp_d     = mp_q;
    if (load_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
      sum_d    = {{W{1'b0}}, addend_i};
      mc_d     = {{W{1'b0}}, mcand_i};
      mp_d     = mplier_i;
    end else if (active_q) begin
      sum_d = sum_q + (mp_q[0] ? mc_q : '0);
      mc_d  = mc_q << 1;
      mp_d  = mp_q >> 1;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        active_d = 1'b0;
        fin_d    = 1'b1;
      end
    end
  end

  assign en = load_i | active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      fin_q    <= 1'b0;
      cnt_q    <= '0;
      sum_q    <= '0;
      mc_q     <= '0;
      mp_q     <= '0;
    end else begin
      active_q <= active_d;
      fin_q    <= fin_d;
      if (en) begin
        cnt_q <= cnt_d;
        sum_q <= sum_d;
        mc_q  <= mc_d;
        mp_q  <= mp_d;
      end
    end
  end

  assign prod_lo_o = sum_q[W-1:0];
  assign fin_o     = fin_q;

  // R3
  mplier_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_q |-> (mp_q == '0));
endmodule

// File: rtl/adj_flag_gen.sv
module adj_flag_gen
  import adj_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]      result_i,
  output logic [FLAG_W-1:0] flags_o
);
  always_comb begin
    flags_o         = '0;
    flags_o[FLG_SF] = result_i[W-1];
    flags_o[FLG_ZF] = (result_i == '0);
    flags_o[FLG_PF] = ~(^result_i[7:0]);
  end
endmodule

// File: rtl/ascii_adjust_md.sv
module ascii_adjust_md
  import adj_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                mode_i,
  input  logic [2*W-1:0]      acc_i,
  input  logic [W-1:0]        base_i,
  output logic [2*W-1:0]      acc_o,
  output logic [FLAG_W-1:0]   flags_o,
  output logic                div_err_o,
  output logic                done_o
);
  localparam int AW = 2 * W;

  logic              busy_q, busy_d;
  logic              mode_q, mode_d;
  logic [AW-1:0]     acc_q, acc_d;
  logic [FLAG_W-1:0] flg_q, flg_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic              accept, zero_div, div_load, mul_load;
  logic              div_fin, mul_fin, fin_any;
  logic [W-1:0]      quo, rem, prod_lo;
  logic [AW-1:0]     res_acc;
  logic [FLAG_W-1:0] res_flg;

  always_comb begin
    accept   = start_i & ~busy_q;
    zero_div = accept & (mode_i == MODE_DIV) & (base_i == '0);
    div_load = accept & (mode_i == MODE_DIV) & (base_i != '0);
    mul_load = accept & (mode_i == MODE_MUL);
  end

  adj_divider #(.W(W)) div_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (div_load),
    .dividend_i (acc_i[W-1:0]),
    .divisor_i  (base_i),
    .quo_o      (quo),
    .rem_o      (rem),
    .fin_o      (div_fin)
  );

  adj_multiplier #(.W(W)) mul_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (mul_load),
    .mcand_i   (base_i),
    .mplier_i  (acc_i[AW-1:W]),
    .addend_i  (acc_i[W-1:0]),
    .prod_lo_o (prod_lo),
    .fin_o     (mul_fin)
  );

  assign res_acc = (mode_q == MODE_DIV) ? {quo, rem} : {{W{1'b0}}, prod_lo};

  adj_flag_gen #(.W(W)) flg_i (
    .result_i (res_acc[W-1:0]),
    .flags_o  (res_flg)
  );

  assign fin_any = div_fin | mul_fin;

  always_comb begin
    busy_d = busy_q;
    mode_d = mode_q;
    acc_d  = acc_q;
    flg_d  = flg_q;
    done_d = fin_any | zero_div;
    err_d  = zero_div;
    if (accept) mode_d = mode_i;
    if (div_load | mul_load) busy_d = 1'b1;
    else if (fin_any)        busy_d = 1'b0;
    if (fin_any) begin
      acc_d = res_acc;
      flg_d = res_flg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mode_q <= MODE_DIV;
      acc_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (accept)  mode_q <= mode_d;
      if (fin_any) begin
        acc_q <= acc_d;
        flg_q <= flg_d;
      end
    end
  end

  assign acc_o     = acc_q;
  assign flags_o   = flg_q;
  assign done_o    = done_q;
  assign div_err_o = err_q;

  // R2
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_err_o |-> done_o);

  // R2
  fault_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_err_o |-> ($stable(acc_o) && $stable(flags_o)));

  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(acc_o) && $stable(flags_o)));

  // R4
  cleared_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_err_o) |->
      (!flags_o[FLG_CF] && !flags_o[FLG_AF] && !flags_o[FLG_OF]));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_err_o) |-> (flags_o[FLG_ZF] == (acc_o[W-1:0] == '0)));

  // R3
  mul_high_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !div_err_o && mode_q == MODE_MUL) |-> (acc_o[AW-1:W] == '0));

  // R7
  single_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_fin && mul_fin));
endmodule

// File: tb/ascii_adjust_md_tb_top.sv
`timescale 1ns/1ps
module ascii_adjust_md_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        mode;
  logic [15:0] acc_in;
  logic [7:0]  base;
  logic [15:0] acc_out;
  logic [5:0]  flags;
  logic        derr;
  logic        done;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ascii_adjust_md dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .mode_i    (mode),
    .acc_i     (acc_in),
    .base_i    (base),
    .acc_o     (acc_out),
    .flags_o   (flags),
    .div_err_o (derr),
    .done_o    (done)
  );

  // {mode, acc_in, base, expected acc_out, expected flags {OF,SF,ZF,AF,PF,CF}}
  localparam logic [46:0] VEC [12] = '{
    {1'b0, 16'h1234, 8'd10,  16'h0502, 6'b000000},
    {1'b0, 16'h00FF, 8'd10,  16'h1905, 6'b000010},
    {1'b0, 16'hAA63, 8'd10,  16'h0909, 6'b000010},
    {1'b0, 16'h5500, 8'd10,  16'h0000, 6'b001010},
    {1'b0, 16'h00C8, 8'd1,   16'hC800, 6'b001010},
    {1'b0, 16'h00FE, 8'd255, 16'h00FE, 6'b010000},
    {1'b0, 16'h0080, 8'd3,   16'h2A02, 6'b000000},
    {1'b1, 16'h0905, 8'd10,  16'h005F, 6'b000010},
    {1'b1, 16'hFFFF, 8'd255, 16'h0000, 6'b001010},
    {1'b1, 16'h0C08, 8'd10,  16'h0080, 6'b010000},
    {1'b1, 16'h0703, 8'd0,   16'h0003, 6'b000010},
    {1'b1, 16'h1A00, 8'd16,  16'h00A0, 6'b010010}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_flags(input logic [7:0] r);
    return {1'b0, r[7], (r == 8'h00), 1'b0, ~(^r), 1'b0};
  endfunction

  // drives one operation, returns the negedge index at which done appeared
  task automatic run_op(input logic m, input logic [15:0] a,
                        input logic [7:0] b, output int lat);
    @(negedge clk);
    start = 1'b1; mode = m; acc_in = a; base = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 30) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic ref_and_check(input logic m, input logic [15:0] a,
                               input logic [7:0] b, input string req);
    logic [15:0] prev_acc, exp_acc, tmp;
    logic [5:0]  prev_f, exp_f;
    logic        exp_err;
    int          exp_lat, lat;
    prev_acc = acc_out;
    prev_f   = flags;
    if (!m && b == 8'd0) begin
      exp_err = 1'b1; exp_acc = prev_acc; exp_f = prev_f; exp_lat = 1;
    end else begin
      exp_err = 1'b0; exp_lat = 10;
      if (!m) exp_acc = {a[7:0] / b, a[7:0] % b};
      else begin
        tmp     = 16'(a[15:8]) * 16'(b) + 16'(a[7:0]);
        exp_acc = {8'h00, tmp[7:0]};
      end
      exp_f = ref_flags(exp_acc[7:0]);
    end
    run_op(m, a, b, lat);
    check(exp_err ? "R2" : "R5", "latency", lat, exp_lat);
    check(req, "acc", acc_out, exp_acc);
    check(exp_err ? "R2" : "R4", "flags", flags, exp_f);
    check("R2", "div_err", derr, exp_err);
    @(negedge clk);
    check("R6", "done low after pulse", done, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    logic [15:0] held;
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; acc_in = '0; base = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "acc in reset", acc_out, 16'h0000);
    check("R9", "flags in reset", flags, 6'd0);
    check("R9", "done in reset", done, 1'b0);
    check("R9", "err in reset", derr, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "done after release", done, 1'b0);

    // vector table
    for (int i = 0; i < 12; i++) begin
      run_op(VEC[i][46], VEC[i][45:30], VEC[i][29:22], lat);
      check("R5", "table latency", lat, 10);
      check(VEC[i][46] ? "R3" : "R1", "table acc", acc_out, VEC[i][21:6]);
      check("R4", "table flags", flags, VEC[i][5:0]);
      check("R2", "table err", derr, 1'b0);
      @(negedge clk);
      check("R6", "table done pulse", done, 1'b0);
    end

    // divide sweep over all AL with several bases (AH junk: R1)
    for (int bi = 0; bi < 5; bi++) begin
      logic [7:0] b;
      case (bi)
        0: b = 8'd10;
        1: b = 8'd1;
        2: b = 8'd255;
        3: b = 8'd0;
        default: b = 8'd7;
      endcase
      for (int al = 0; al < 256; al++)
        ref_and_check(1'b0, {8'(al * 37), 8'(al)}, b, (b == 0) ? "R2" : "R1");
    end

    // random triples in both modes
    for (int k = 0; k < 300; k++) begin
      logic m;
      m = k[0];
      ref_and_check(m, 16'($urandom), 8'($urandom), m ? "R3" : "R1");
    end

    // R7: start held and operands changed while busy
    @(negedge clk);
    start = 1'b1; mode = 1'b0; acc_in = 16'h0064; base = 8'd7;
    @(posedge clk);
    @(negedge clk);
    mode = 1'b1; acc_in = 16'hFFFF; base = 8'd0;
    lat = 1;
    repeat (3) begin
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    while (!done && lat < 30) begin
      @(negedge clk);
      lat++;
    end
    check("R7", "busy latency", lat, 10);
    check("R7", "busy result", acc_out, 16'h0E02);
    check("R7", "busy err", derr, 1'b0);
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      check("R7", "no extra done", done, 1'b0);
    end

    // R8: outputs hold while inputs wander without start
    held = acc_out;
    for (int c = 0; c < 6; c++) begin
      acc_in = 16'($urandom); base = 8'($urandom); mode = ~mode;
      @(negedge clk);
      check("R8", "acc hold", acc_out, held);
      check("R8", "flags hold", flags, 6'b000000);
    end

    // R9: reset mid-operation
    @(negedge clk);
    start = 1'b1; mode = 1'b1; acc_in = 16'h0905; base = 8'd10;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", "acc mid reset", acc_out, 16'h0000);
    check("R9", "done mid reset", done, 1'b0);
    rst_n = 1'b1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      check("R9", "abandoned op", done, 1'b0);
    end
    ref_and_check(1'b0, 16'h0057, 8'd10, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule